// File: doc/BRIEF.md
# Auto-Restart Protection Sequencer

This block supervises the switching stage of an off-line PWM controller. Comparator flags from the analog front end report supply, line, feedback, temperature and current-sense conditions. The block sees the supply's charge and discharge cycles only through the turn-on and turn-off flags. Each fault condition must persist for its own blanking time, counted in ticks of an external 1 µs strobe, before it is accepted. An accepted fault removes the gate enable and records a fault code.

Once a fault is latched, the block waits for later supply charging cycles before switching again. The restart rule depends on the fault. Under the plain rule, switching resumes at the next charging cycle. Under the hold rule, switching resumes at the first charging cycle on which the fault has gone away. Under the alternate rule, every second charging cycle is skipped. Every start, including the first one after power-up, is marked by a single-cycle soft-start request.

Top module: `restart_supervisor`

## Requirements
- R1: After reset, gateEn is 0, softStart is 0 and faultCode is 0. The block then waits for a charging cycle before it switches.
- R2: A charging cycle is a rising edge of vccOn. In the idle state, a charging cycle sets gateEn in the following clock cycle, and softStart is 1 for exactly that one cycle.
- R3: While running, vccLow held for UV_BLANK ticks clears gateEn and sets faultCode 6. Under the plain rule, the next charging cycle restarts the block.
- R4: While running, vccOv held for VOV_BLANK ticks clears gateEn and sets faultCode 1. The check is masked while burstMode and burstIdle are both 1, and it still runs in burst mode while burstIdle is 0.
- R5: Under the alternate rule, used by codes 1 and 2, the first charging cycle after the fault latches is skipped and the second one restarts the block. The skip counter starts over at each new latch.
- R6: lineOv held for LOV_BLANK ticks sets faultCode 3 under the hold rule. A charging cycle restarts the block only if lineOv is 0 at that cycle.
- R7: fbHigh held for OLP_BLANK ticks sets faultCode 2. The overload check does not run while burstMode is 1.
- R8: otHot held for OTP_BLANK ticks sets faultCode 4 under the hold rule. The thermal fault stays in force until otCool has been seen, even if otHot has already dropped.
- R9: csShort held for CSS_BLANK ticks sets faultCode 5 under the plain rule.
- R10: When several faults qualify in the same cycle, the lowest code wins, in the order 1, 2, 3, 4, 5, 6. The two alternate-rule faults therefore come first.
- R11: A condition that drops before its blanking time has elapsed has no effect, and its blanking count starts again from zero.
- R12: faultCode reads 0 whenever gateEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tick | input | 1 | 1 µs time strobe for the blanking counts |
| vccOn | input | 1 | Supply is above the turn-on level |
| vccLow | input | 1 | Supply is below the turn-off level |
| vccOv | input | 1 | Supply over-voltage |
| lineOv | input | 1 | Line input over-voltage |
| fbHigh | input | 1 | Feedback is above the overload level |
| otHot | input | 1 | Die temperature is above the trip point |
| otCool | input | 1 | Die temperature is below the release point |
| csShort | input | 1 | Current-sense input is shorted to ground |
| burstMode | input | 1 | Burst operation is active |
| burstIdle | input | 1 | Burst is in its non-switching phase |
| gateEn | output | 1 | Switching is allowed |
| softStart | output | 1 | One-cycle request to start a soft-start sequence |
| faultCode | output | 3 | Cause of the latched fault, 0 when none |

## Verification
The bench holds each condition for just under and just over its blanking time. A counter that is off by one, or that does not restart after a glitch, therefore shows up as a trip that comes early or never comes. The bench replays supply cycles after each fault. A design that confuses the skip parity would restart on the wrong cycle. A design that ignores the line level or thermal hysteresis would start switching while the fault is still present. The bench also raises several faults at once, which catches a wrong priority in the reported code, and it checks that the burst masks suppress only the checks they are meant to suppress.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  localparam int NFLT = 6;

  // Bit index i of the qualified vector corresponds to code i+1 (priority order).
  typedef enum logic [2:0] {
    FC_NONE        = 3'd0,
    FC_SUPPLY_OV   = 3'd1,
    FC_OVERLOAD    = 3'd2,
    FC_LINE_OV     = 3'd3,
    FC_THERMAL     = 3'd4,
    FC_SENSE_SHORT = 3'd5,
    FC_UNDERVOLT   = 3'd6
  } faultCode_e;

  typedef enum logic [1:0] {
    POL_PLAIN     = 2'd0,
    POL_HOLD      = 2'd1,
    POL_ALTERNATE = 2'd2
  } policy_e;

  typedef struct packed {
    logic armed;   // blanking counters may run
  } ctlStrobe_t;

  typedef struct packed {
    logic [NFLT-1:0] qual;
    logic            chargeEdge;
    logic            lineHigh;
    logic            hotHeld;
  } dpStatus_t;

  function automatic policy_e policyOf(faultCode_e c);
    case (c)
      FC_SUPPLY_OV, FC_OVERLOAD: policyOf = POL_ALTERNATE;
      FC_LINE_OV, FC_THERMAL:    policyOf = POL_HOLD;
      default:                   policyOf = POL_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/rsup_datapath.sv
module rsup_datapath
  import rsup_pkg::*;
#(
  parameter int VOV_BLANK = 55,
  parameter int OLP_BLANK = 54000,
  parameter int LOV_BLANK = 250,
  parameter int OTP_BLANK = 50,
  parameter int CSS_BLANK = 1,
  parameter int UV_BLANK  = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       vccOn,
  input  logic       vccLow,
  input  logic       vccOv,
  input  logic       lineOv,
  input  logic       fbHigh,
  input  logic       otHot,
  input  logic       otCool,
  input  logic       csShort,
  input  logic       burstMode,
  input  logic       burstIdle,
  input  ctlStrobe_t ctl,
  output dpStatus_t  stat
);
  localparam int LIM [NFLT] = '{VOV_BLANK, OLP_BLANK, LOV_BLANK,
                                OTP_BLANK, CSS_BLANK, UV_BLANK};

  function automatic int maxLim();
    int m = 1;
    for (int i = 0; i < NFLT; i++) if (LIM[i] > m) m = LIM[i];
    return m;
  endfunction

  localparam int CW = $clog2(maxLim() + 1);

  logic [NFLT-1:0] cond;
  logic [NFLT-1:0] qual;
  logic            vccOnPrev;
  logic            hotHeld;

  always_comb begin
    cond    = '0;
    cond[0] = vccOv & ~(burstMode & burstIdle);
    cond[1] = fbHigh & ~burstMode;
    cond[2] = lineOv;
    cond[3] = otHot;
    cond[4] = csShort;
    cond[5] = vccLow;
  end

  for (genvar i = 0; i < NFLT; i++) begin : g_blank
    logic [CW-1:0] cnt;
    localparam logic [CW-1:0] LIMV = CW'(LIM[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        cnt <= '0;
      else if (!ctl.armed || !cond[i])  cnt <= '0;
      else if (tick && cnt != LIMV)     cnt <= cnt + 1'b1;
    end
    assign qual[i] = ctl.armed & cond[i] & (cnt == LIMV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vccOnPrev <= 1'b0;
      hotHeld   <= 1'b0;
    end else begin
      vccOnPrev <= vccOn;
      if (qual[3])     hotHeld <= 1'b1;
      else if (otCool) hotHeld <= 1'b0;
    end
  end

  assign stat.qual       = qual;
  assign stat.chargeEdge = vccOn & ~vccOnPrev;
  assign stat.lineHigh   = lineOv;
  assign stat.hotHeld    = hotHeld;
endmodule

// File: rtl/rsup_control.sv
module rsup_control
  import rsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       gateEn,
  output logic       softStart,
  output logic [2:0] faultCode
);
  logic       running;
  policy_e    policy;
  faultCode_e code;
  logic       oddSeen;
  faultCode_e pick;
  logic       faultOk;

  always_comb begin
    pick = FC_NONE;
    for (int i = NFLT - 1; i >= 0; i--)
      if (stat.qual[i]) pick = faultCode_e'(i + 1);
  end

  always_comb begin
    case (code)
      FC_LINE_OV: faultOk = ~stat.lineHigh;
      FC_THERMAL: faultOk = ~stat.hotHeld;
      default:    faultOk = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      policy    <= POL_PLAIN;
      code      <= FC_NONE;
      oddSeen   <= 1'b0;
      softStart <= 1'b0;
    end else begin
      softStart <= 1'b0;
      if (running) begin
        if (pick != FC_NONE) begin
          running <= 1'b0;
          code    <= pick;
          policy  <= policyOf(pick);
          oddSeen <= 1'b0;
        end
      end else if (stat.chargeEdge) begin
        if ((policy == POL_PLAIN) ||
            (policy == POL_HOLD && faultOk) ||
            (policy == POL_ALTERNATE && oddSeen)) begin
          running   <= 1'b1;
          code      <= FC_NONE;
          softStart <= 1'b1;
        end else if (policy == POL_ALTERNATE) begin
          oddSeen <= 1'b1;
        end
      end
    end
  end

  assign ctl.armed = running;
  assign gateEn    = running;
  assign faultCode = code;
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
  import rsup_pkg::*;
#(
  parameter int VOV_BLANK = 55,
  parameter int OLP_BLANK = 54000,
  parameter int LOV_BLANK = 250,
  parameter int OTP_BLANK = 50,
  parameter int CSS_BLANK = 1,
  parameter int UV_BLANK  = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       vccOn,
  input  logic       vccLow,
  input  logic       vccOv,
  input  logic       lineOv,
  input  logic       fbHigh,
  input  logic       otHot,
  input  logic       otCool,
  input  logic       csShort,
  input  logic       burstMode,
  input  logic       burstIdle,
  output logic       gateEn,
  output logic       softStart,
  output logic [2:0] faultCode
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  rsup_datapath #(
    .VOV_BLANK(VOV_BLANK), .OLP_BLANK(OLP_BLANK), .LOV_BLANK(LOV_BLANK),
    .OTP_BLANK(OTP_BLANK), .CSS_BLANK(CSS_BLANK), .UV_BLANK(UV_BLANK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .vccOn(vccOn), .vccLow(vccLow),
    .vccOv(vccOv), .lineOv(lineOv), .fbHigh(fbHigh), .otHot(otHot),
    .otCool(otCool), .csShort(csShort), .burstMode(burstMode),
    .burstIdle(burstIdle), .ctl(ctl), .stat(stat)
  );

  rsup_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl),
    .gateEn(gateEn), .softStart(softStart), .faultCode(faultCode)
  );
endmodule

// File: rtl/restart_supervisor_chk.sv
module restart_supervisor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vccOn,
  input logic       lineOv,
  input logic       gateEn,
  input logic       softStart,
  input logic [2:0] faultCode
);
  p_ss_with_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    softStart |-> gateEn);

  p_ss_on_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> softStart);

  p_start_after_supply_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> $past(vccOn));

  p_code_clear_run_r12: assert property (@(posedge clk) disable iff (!rstN)
    gateEn |-> (faultCode == 3'd0));

  p_line_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEn && faultCode == 3'd3 && lineOv) |=> !gateEn);

  p_ss_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    softStart |=> !softStart);
endmodule

bind restart_supervisor restart_supervisor_chk u_chk (
  .clk(clk), .rstN(rstN), .vccOn(vccOn), .lineOv(lineOv),
  .gateEn(gateEn), .softStart(softStart), .faultCode(faultCode)
);

// File: tb/restart_supervisor_bench.sv
module restart_supervisor_bench;
  localparam int B_VOV = 8, B_OLP = 30, B_LOV = 20, B_OTP = 8, B_CSS = 8, B_UV = 8;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1;
  logic vccOn = 0, vccLow = 0, vccOv = 0, lineOv = 0, fbHigh = 0;
  logic otHot = 0, otCool = 0, csShort = 0, burstMode = 0, burstIdle = 0;
  logic gateEn, softStart;
  logic [2:0] faultCode;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  restart_supervisor #(
    .VOV_BLANK(B_VOV), .OLP_BLANK(B_OLP), .LOV_BLANK(B_LOV),
    .OTP_BLANK(B_OTP), .CSS_BLANK(B_CSS), .UV_BLANK(B_UV)
  ) u_restart_supervisor (
    .clk(clk), .rstN(rstN), .tick(tick), .vccOn(vccOn), .vccLow(vccLow),
    .vccOv(vccOv), .lineOv(lineOv), .fbHigh(fbHigh), .otHot(otHot),
    .otCool(otCool), .csShort(csShort), .burstMode(burstMode),
    .burstIdle(burstIdle), .gateEn(gateEn), .softStart(softStart),
    .faultCode(faultCode)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; vccOn = 0; vccLow = 0; vccOv = 0; lineOv = 0; fbHigh = 0;
    otHot = 0; otCool = 0; csShort = 0; burstMode = 0; burstIdle = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic chargeCycle(output logic g, output logic s);
    @(negedge clk) vccOn = 0;
    repeat (3) @(negedge clk);
    vccOn = 1;
    @(negedge clk);
    g = gateEn; s = softStart;
  endtask

  task automatic startUp();
    logic g, s;
    doReset();
    chargeCycle(g, s);
  endtask

  task automatic t_reset();
    logic g, s;
    doReset();
    check("R1 gate after reset", gateEn, 0);
    check("R1 softStart after reset", softStart, 0);
    check("R1 code after reset", faultCode, 0);
    chargeCycle(g, s);
    check("R2 gate on first charge", g, 1);
    check("R2 softStart pulse", s, 1);
    @(negedge clk);
    check("R2 softStart single cycle", softStart, 0);
    check("R12 code zero while running", faultCode, 0);
  endtask

  task automatic t_undervolt();
    logic g, s;
    startUp();
    vccLow = 1;
    repeat (B_UV - 1) @(negedge clk);
    check("R3 no trip before blank", gateEn, 1);
    repeat (3) @(negedge clk);
    check("R3 gate off after blank", gateEn, 0);
    check("R3 code", faultCode, 6);
    vccLow = 0;
    chargeCycle(g, s);
    check("R3 plain restart", g, 1);
    check("R3 restart softStart", s, 1);
  endtask

  task automatic t_glitch();
    startUp();
    repeat (2) begin
      vccLow = 1;
      repeat (B_UV - 3) @(negedge clk);
      vccLow = 0;
      @(negedge clk);
    end
    check("R11 short pulses ignored", gateEn, 1);
    check("R11 code stays zero", faultCode, 0);
  endtask

  task automatic t_supply_ov();
    logic g, s;
    startUp();
    burstMode = 1; burstIdle = 1; vccOv = 1;
    repeat (B_VOV + 6) @(negedge clk);
    check("R4 masked in burst idle", gateEn, 1);
    burstIdle = 0;
    repeat (B_VOV + 3) @(negedge clk);
    check("R4 trips in burst on", gateEn, 0);
    check("R4 code", faultCode, 1);
    vccOv = 0; burstMode = 0;
    chargeCycle(g, s);
    check("R5 first cycle skipped", g, 0);
    chargeCycle(g, s);
    check("R5 second cycle restarts", g, 1);
    check("R5 restart softStart", s, 1);
    vccOv = 1;
    repeat (B_VOV + 3) @(negedge clk);
    vccOv = 0;
    chargeCycle(g, s);
    check("R5 parity restarts on new latch", g, 0);
    chargeCycle(g, s);
    check("R5 restart after new latch", g, 1);
  endtask

  task automatic t_overload();
    logic g, s;
    startUp();
    burstMode = 1; fbHigh = 1;
    repeat (B_OLP + 6) @(negedge clk);
    check("R7 masked in burst", gateEn, 1);
    burstMode = 0;
    repeat (B_OLP - 1) @(negedge clk);
    check("R7 no trip before blank", gateEn, 1);
    repeat (3) @(negedge clk);
    check("R7 trips", gateEn, 0);
    check("R7 code", faultCode, 2);
    fbHigh = 0;
    chargeCycle(g, s);
    check("R5 overload skip", g, 0);
    chargeCycle(g, s);
    check("R5 overload restart", g, 1);
  endtask

  task automatic t_line_ov();
    logic g, s;
    startUp();
    lineOv = 1;
    repeat (B_LOV + 3) @(negedge clk);
    check("R6 trips", gateEn, 0);
    check("R6 code", faultCode, 3);
    chargeCycle(g, s);
    check("R6 held while line high", g, 0);
    chargeCycle(g, s);
    check("R6 still held", g, 0);
    lineOv = 0;
    chargeCycle(g, s);
    check("R6 restart after clear", g, 1);
  endtask

  task automatic t_thermal();
    logic g, s;
    startUp();
    otHot = 1;
    repeat (B_OTP + 3) @(negedge clk);
    check("R8 trips", gateEn, 0);
    check("R8 code", faultCode, 4);
    otHot = 0;
    chargeCycle(g, s);
    check("R8 hysteresis holds", g, 0);
    @(negedge clk) otCool = 1;
    @(negedge clk) otCool = 0;
    chargeCycle(g, s);
    check("R8 restart after cool", g, 1);
  endtask

  task automatic t_sense_short();
    logic g, s;
    startUp();
    csShort = 1;
    repeat (B_CSS + 3) @(negedge clk);
    check("R9 trips", gateEn, 0);
    check("R9 code", faultCode, 5);
    csShort = 0;
    chargeCycle(g, s);
    check("R9 plain restart", g, 1);
  endtask

  task automatic t_priority();
    startUp();
    vccOv = 1; otHot = 1; csShort = 1; vccLow = 1;
    repeat (B_VOV + 3) @(negedge clk);
    check("R10 supply ov wins", faultCode, 1);
    startUp();
    otHot = 1; csShort = 1; vccLow = 1;
    repeat (B_OTP + 3) @(negedge clk);
    check("R10 thermal over short", faultCode, 4);
    startUp();
    csShort = 1; vccLow = 1;
    repeat (B_CSS + 3) @(negedge clk);
    check("R10 short over undervolt", faultCode, 5);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_undervolt();
    t_glitch();
    t_supply_ov();
    t_overload();
    t_line_ov();
    t_thermal();
    t_sense_short();
    t_priority();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule